// File: doc/BRIEF.md
# Receive System-Side Serializer with External Bit Timing

This block moves one frame of already-mapped receive data, plus a per-channel signaling nibble, onto a serial system bus. The system side supplies the bit clock and a frame pulse. The block does not clock its logic from the bit clock. A fast core clock oversamples both pins, finds the clock edges, and from those edges decides when the frame pulse is sampled and when the serial outputs change. Upstream logic fills a per-channel store through a simple write port. The serializer reads that store as it walks through the frame.

Configuration inputs choose the following:
- the bit-clock edge that samples the frame pulse;
- the edge that updates the data and signaling outputs;
- the polarity of the frame pulse;
- single-rate or double-rate bit clocking, and in double-rate mode, which of the two edges in a bit updates the outputs.

A channel offset and a bit offset move the start of the output frame away from the frame pulse. A frame-period checker sets a sticky error flag when a frame pulse arrives at a spacing that is not a whole number of frames. An interrupt output follows that flag when its enable input is set.

The frame holds `CHANNELS` x `CH_BITS` bits. With the defaults this is 32 x 8 = 256 bits, the 125 µs frame at 2.048 Mb/s. Both `CHANNELS` and `CH_BITS` must be powers of two.

Top module: `rx_sys_serializer`

## Requirements
- R1: After reset, `ser_data`, `ser_sig`, `frame_err` and `irq` are 0. Until the first frame pulse is accepted, the serial outputs stay 0.
- R2: The frame pulse is active when `fp_in ^ cfg_fp_inv` is 1. It is sampled only on bit-clock edges of the type chosen by `cfg_fp_fall` (0 rising, 1 falling).
- R3: The outputs update on the edge type chosen by `cfg_data_fall` (0 rising, 1 falling).
  - If both edge selections are equal, the edge that samples the pulse is the first edge of bit 0.
  - If they differ, the pulse is taken half a clock ahead, and the next update-type edge is the first edge of bit 0.
- R4: With `cfg_dbl_rate`=1, each bit spans two update-type edges, counted from the edge that starts the frame. `cfg_upd_second`=0 updates the outputs on the first of the two edges; `cfg_upd_second`=1 updates them on the second.
- R5: With `cfg_dbl_rate`=1, the pulse counts only on the first edge of a bit. If the pulse is still active on the second edge, that edge does not restart the frame.
- R6: Frame bit position p carries channel p/`CH_BITS`, MSB first. On the signaling line, positions 4..7 of a channel carry the channel's 4-bit signaling nibble, bit 3 first. Positions 0..3 carry 0.
- R7: Channel 0, bit 7 appears at bit index `cfg_ch_ofs`*8 + `cfg_bit_ofs` after the frame start, and the frame wraps modulo 256 bits.
- R8: A frame pulse that arrives a whole number of frames after the previous accepted pulse leaves `frame_err` unchanged. Any other spacing sets `frame_err` and realigns the output frame to the new pulse. The first pulse after reset is not checked.
- R9: `frame_err` stays set until a cycle with `stat_clr`=1. If an error occurs in the same cycle as the clear, the flag is set.
- R10: `irq` equals `frame_err & cfg_irq_en`, one core cycle later.
- R11: `wr_en` writes `wr_data` and `wr_sig` into the store entry for channel `wr_ch`. The serializer reads its bits from that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | System bit clock |
| fp_in | input | 1 | System frame pulse |
| cfg_fp_fall | input | 1 | Edge that samples the frame pulse (1 = falling) |
| cfg_data_fall | input | 1 | Edge that updates the outputs (1 = falling) |
| cfg_fp_inv | input | 1 | Frame pulse active low when 1 |
| cfg_dbl_rate | input | 1 | Bit clock runs at twice the data rate |
| cfg_upd_second | input | 1 | Double rate: update on the second edge of a bit |
| cfg_ch_ofs | input | 5 | Channel offset |
| cfg_bit_ofs | input | 3 | Bit offset |
| cfg_irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Clear strobe for the error flag |
| wr_en | input | 1 | Channel store write enable |
| wr_ch | input | 5 | Channel store write address |
| wr_data | input | 8 | Channel data byte |
| wr_sig | input | 4 | Channel signaling nibble |
| ser_data | output | 1 | Serial data |
| ser_sig | output | 1 | Serial signaling |
| frame_err | output | 1 | Sticky frame-spacing error flag |
| irq | output | 1 | Interrupt |

## Verification
Two functions can act in the same core cycle: the frame-spacing checker setting the sticky flag, and the clear strobe resetting it. The bench provokes the collision by holding `stat_clr` high for a whole run in which a misaligned frame pulse arrives. The rising edges of `frame_err` are counted. Exactly one rise during that run shows that the set won. The flag being 0 afterwards shows that the still-held clear took effect on the following cycle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Synchronizer depth for the externally timed pins.
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic fp_fall;     // frame pulse sampling edge
    logic data_fall;   // output update edge
    logic fp_inv;      // frame pulse active low
    logic dbl_rate;    // two bit-clock periods per bit
    logic upd_second;  // update on second edge of a double-rate bit
  } rxs_cfg_t;

endpackage

// File: rtl/rxs_edge_det.sv
module rxs_edge_det
  import rxs_pkg::*;
#(
  parameter int SYNC = SYNC_STAGES
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bclk_pin,
  input  logic     fp_pin,
  input  rxs_cfg_t cfg,
  output logic     fp_evt,
  output logic     fp_lvl,
  output logic     data_evt
);

  logic [SYNC:0]   bsh;
  logic [SYNC-1:0] fsh;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsh <= '0;
      fsh <= '0;
    end else begin
      bsh <= {bsh[SYNC-1:0], bclk_pin};
      fsh <= {fsh[SYNC-2:0], fp_pin};
    end
  end

  // Pulse and clock travel through equal-depth synchronizers, so the pulse
  // level seen here is the one present at the detected edge.
  assign rise     = bsh[SYNC-1] & ~bsh[SYNC];
  assign fall     = ~bsh[SYNC-1] & bsh[SYNC];
  assign fp_evt   = cfg.fp_fall   ? fall : rise;
  assign data_evt = cfg.data_fall ? fall : rise;
  assign fp_lvl   = fsh[SYNC-1] ^ cfg.fp_inv;

endmodule

// File: rtl/rxs_bit_timer.sv
module rxs_bit_timer #(
  parameter int FRAME_BITS = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fp_evt,
  input  logic          fp_lvl,
  input  logic          data_evt,
  input  logic          dbl_rate,
  input  logic          upd_second,
  output logic          tick,
  output logic [BW-1:0] bit_idx,
  output logic          err_pulse
);

  localparam int BW = $clog2(FRAME_BITS);
  localparam int EW = BW + 1;

  logic [EW-1:0] ecnt, ecnt_nx, last_c;
  logic          locked, pend, prev_hit;
  logic          fp_raw, fp_hit, start, adv, upd;

  assign last_c  = dbl_rate ? EW'(2*FRAME_BITS-1) : EW'(FRAME_BITS-1);
  assign fp_raw  = fp_evt & fp_lvl;
  // In double-rate mode a pulse still active on the next sampling edge
  // belongs to the same bit and is not a new frame start.
  assign fp_hit  = fp_raw & ~(dbl_rate & prev_hit);
  assign start   = data_evt & (fp_hit | pend);
  assign ecnt_nx = (start || ecnt == last_c) ? '0 : ecnt + 1'b1;
  assign adv     = data_evt & (start | locked);
  assign upd     = adv & (~dbl_rate | (ecnt_nx[0] == upd_second));

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt      <= '0;
      locked    <= 1'b0;
      pend      <= 1'b0;
      prev_hit  <= 1'b0;
      tick      <= 1'b0;
      bit_idx   <= '0;
      err_pulse <= 1'b0;
    end else begin
      if (fp_evt) prev_hit <= fp_raw;
      pend <= data_evt ? 1'b0 : (pend | fp_hit);
      if (adv) ecnt <= ecnt_nx;
      if (start) locked <= 1'b1;
      err_pulse <= start & locked & (ecnt != last_c);
      tick      <= upd;
      if (upd) bit_idx <= dbl_rate ? ecnt_nx[BW:1] : ecnt_nx[BW-1:0];
    end
  end

  // R8: an accepted frame start restarts the edge count
  a_r8_start_zeroes: assert property (@(posedge clk) disable iff (rst)
    start |=> (ecnt == '0));

  // R4: the count wraps at the frame length for the active rate
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && !start && ecnt == last_c) |=> (ecnt == '0));

  // R8: an error is only reported right after a frame start
  a_r8_err_at_start: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(start));

endmodule

// File: rtl/rxs_chan_ram.sv
module rxs_chan_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 12
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxs_shifter.sv
module rxs_shifter #(
  parameter int CHANNELS = 32,
  parameter int CH_BITS  = 8,
  parameter int SIG_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [BW-1:0]         bit_idx,
  input  logic [CW-1:0]         ch_ofs,
  input  logic [PW-1:0]         bit_ofs,
  output logic [CW-1:0]         rd_addr,
  input  logic [WW-1:0]         rd_word,
  output logic                  ser_data,
  output logic                  ser_sig
);

  localparam int CW = $clog2(CHANNELS);
  localparam int PW = $clog2(CH_BITS);
  localparam int BW = CW + PW;
  localparam int WW = CH_BITS + SIG_BITS;

  logic [BW-1:0]      pos;
  logic               va, vb;
  logic [PW-1:0]      bpa, bpb, rix;
  logic [CH_BITS-1:0] dat, sig_ext;

  // Position inside the frame, counted from channel 0 bit 7.
  assign pos = bit_idx - {ch_ofs, bit_ofs};

  always_ff @(posedge clk) begin
    if (rst) begin
      va      <= 1'b0;
      vb      <= 1'b0;
      rd_addr <= '0;
      bpa     <= '0;
      bpb     <= '0;
    end else begin
      va <= tick;
      vb <= va;
      if (tick) begin
        rd_addr <= pos[BW-1:PW];
        bpa     <= pos[PW-1:0];
      end
      bpb <= bpa;
    end
  end

  assign dat     = rd_word[CH_BITS-1:0];
  assign sig_ext = CH_BITS'(rd_word[WW-1:CH_BITS]);
  assign rix     = ~bpb;  // MSB first

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      ser_sig  <= 1'b0;
    end else if (vb) begin
      ser_data <= dat[rix];
      ser_sig  <= sig_ext[rix];
    end
  end

  // R6: the signaling line is low in the leading positions of a channel
  a_r6_sig_low_lead: assert property (@(posedge clk) disable iff (rst)
    (vb && bpb < PW'(CH_BITS-SIG_BITS)) |=> !ser_sig);

endmodule

// File: rtl/rx_sys_serializer.sv
module rx_sys_serializer
  import rxs_pkg::*;
#(
  parameter int CHANNELS = 32,
  parameter int CH_BITS  = 8,
  parameter int SIG_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bclk_in,
  input  logic                        fp_in,
  input  logic                        cfg_fp_fall,
  input  logic                        cfg_data_fall,
  input  logic                        cfg_fp_inv,
  input  logic                        cfg_dbl_rate,
  input  logic                        cfg_upd_second,
  input  logic [$clog2(CHANNELS)-1:0] cfg_ch_ofs,
  input  logic [$clog2(CH_BITS)-1:0]  cfg_bit_ofs,
  input  logic                        cfg_irq_en,
  input  logic                        stat_clr,
  input  logic                        wr_en,
  input  logic [$clog2(CHANNELS)-1:0] wr_ch,
  input  logic [CH_BITS-1:0]          wr_data,
  input  logic [SIG_BITS-1:0]         wr_sig,
  output logic                        ser_data,
  output logic                        ser_sig,
  output logic                        frame_err,
  output logic                        irq
);

  localparam int CW         = $clog2(CHANNELS);
  localparam int PW         = $clog2(CH_BITS);
  localparam int BW         = CW + PW;
  localparam int WW         = CH_BITS + SIG_BITS;
  localparam int FRAME_BITS = CHANNELS * CH_BITS;

  rxs_cfg_t      cfg;
  logic          fp_evt, fp_lvl, data_evt;
  logic          tick, err_pulse;
  logic [BW-1:0] bit_idx;
  logic [CW-1:0] rd_addr;
  logic [WW-1:0] rd_word;

  assign cfg = '{fp_fall: cfg_fp_fall, data_fall: cfg_data_fall,
                 fp_inv: cfg_fp_inv, dbl_rate: cfg_dbl_rate,
                 upd_second: cfg_upd_second};

  rxs_edge_det #(.SYNC(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk_pin(bclk_in), .fp_pin(fp_in), .cfg(cfg),
    .fp_evt(fp_evt), .fp_lvl(fp_lvl), .data_evt(data_evt)
  );

  rxs_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst(rst), .fp_evt(fp_evt), .fp_lvl(fp_lvl),
    .data_evt(data_evt), .dbl_rate(cfg_dbl_rate),
    .upd_second(cfg_upd_second), .tick(tick), .bit_idx(bit_idx),
    .err_pulse(err_pulse)
  );

  rxs_chan_ram #(.DEPTH(CHANNELS), .WIDTH(WW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ch), .wdata({wr_sig, wr_data}),
    .raddr(rd_addr), .rdata(rd_word)
  );

  rxs_shifter #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS), .SIG_BITS(SIG_BITS))
  u_shift (
    .clk(clk), .rst(rst), .tick(tick), .bit_idx(bit_idx),
    .ch_ofs(cfg_ch_ofs), .bit_ofs(cfg_bit_ofs), .rd_addr(rd_addr),
    .rd_word(rd_word), .ser_data(ser_data), .ser_sig(ser_sig)
  );

  // Sticky status: a new error wins over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_err <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (err_pulse)     frame_err <= 1'b1;
      else if (stat_clr) frame_err <= 1'b0;
      irq <= frame_err & cfg_irq_en;
    end
  end

  // R9: set has priority over clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> frame_err);

  // R9: a clear without a new error drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !err_pulse) |=> !frame_err);

  // R8: the flag holds until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !stat_clr) |=> frame_err);

  // R10: interrupt only follows an enabled, set flag
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(frame_err && cfg_irq_en));

endmodule

// File: tb/test_rx_sys_serializer.sv
module test_rx_sys_serializer;

  localparam int CH = 32;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_in = 1'b0, fp_in = 1'b0;
  logic cfg_fp_fall = 0, cfg_data_fall = 0, cfg_fp_inv = 0;
  logic cfg_dbl_rate = 0, cfg_upd_second = 0, cfg_irq_en = 0, stat_clr = 0;
  logic [4:0] cfg_ch_ofs = '0;
  logic [2:0] cfg_bit_ofs = '0;
  logic wr_en = 0;
  logic [4:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] wr_sig = '0;
  logic ser_data, ser_sig, frame_err, irq;

  always #10 clk = ~clk;

  rx_sys_serializer i_rx_sys_serializer (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .fp_in(fp_in),
    .cfg_fp_fall(cfg_fp_fall), .cfg_data_fall(cfg_data_fall),
    .cfg_fp_inv(cfg_fp_inv), .cfg_dbl_rate(cfg_dbl_rate),
    .cfg_upd_second(cfg_upd_second), .cfg_ch_ofs(cfg_ch_ofs),
    .cfg_bit_ofs(cfg_bit_ofs), .cfg_irq_en(cfg_irq_en), .stat_clr(stat_clr),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .wr_sig(wr_sig),
    .ser_data(ser_data), .ser_sig(ser_sig), .frame_err(frame_err), .irq(irq)
  );

  typedef struct { logic d; logic s; string tag; } exp_t;
  exp_t q[$];
  event smp_ev;
  int n_chk = 0, n_fail = 0, rise_cnt = 0, gp = 0;
  int starts[$];
  logic [7:0] mdat [CH];
  logic [3:0] msig [CH];

  always @(posedge frame_err) rise_cnt++;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Monitor: pops expected serial bits and compares them at the sample point.
  initial begin
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(ser_data === e.d && ser_sig === e.s, e.tag, "serial {data,sig}",
            int'({ser_data, ser_sig}), int'({e.d, e.s}));
      end
    end
  end

  function automatic int cur_start(int p);
    int r = -1;
    foreach (starts[i]) if (starts[i] <= p && starts[i] > r) r = starts[i];
    return r;
  endfunction

  task automatic setup(bit fe, bit de, bit inv, bit dbl, bit upd,
                       int cho, int bo);
    @(negedge clk);
    rst = 1'b1;
    cfg_fp_fall = fe; cfg_data_fall = de; cfg_fp_inv = inv;
    cfg_dbl_rate = dbl; cfg_upd_second = upd;
    cfg_ch_ofs = 5'(cho); cfg_bit_ofs = 3'(bo);
    bclk_in = de; fp_in = inv;
    gp = 0;
    starts.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Driver: quarter-period stepping of the bit clock and frame pulse; pushes
  // the expected serial bit after each update edge.
  task automatic run(int nper, string tag);
    for (int p = gp; p < gp + nper; p++) begin
      for (int ph = 0; ph < 4; ph++) begin
        int qq = 4*p + ph;
        bit on = 1'b0;
        foreach (starts[i]) begin
          int q0 = 4*starts[i];
          int lo = (cfg_fp_fall == cfg_data_fall) ? q0 - 1 : q0 - 3;
          int hi = lo + 2 + (cfg_dbl_rate ? 4 : 0);
          if (qq >= lo && qq < hi) on = 1'b1;
        end
        if (ph == 0) bclk_in = ~cfg_data_fall;
        if (ph == 2) bclk_in = cfg_data_fall;
        fp_in = on ^ cfg_fp_inv;
        if (ph == 3) begin
          int s0 = cur_start(p);
          exp_t e;
          if (s0 < 0) begin
            e.d = 0; e.s = 0; e.tag = "R1 idle before pulse";
            q.push_back(e);
          end else begin
            int k = p - s0;
            bit go = !cfg_dbl_rate || ((k % 2) == int'(cfg_upd_second));
            if (go) begin
              int idx = cfg_dbl_rate ? (k/2) % FB : k % FB;
              int off = int'(cfg_ch_ofs)*8 + int'(cfg_bit_ofs);
              int pos = ((idx - off) % FB + FB) % FB;
              int ch = pos / 8, bp = pos % 8;
              e.d = mdat[ch][7-bp];
              e.s = (bp >= 4) ? msig[ch][7-bp] : 1'b0;
              e.tag = tag;
              q.push_back(e);
            end
          end
          -> smp_ev;
        end
        repeat (4) @(negedge clk);
      end
    end
    gp += nper;
  endtask

  initial begin
    int rc0;
    // R11: load the channel store
    for (int c = 0; c < CH; c++) begin
      mdat[c] = 8'(c*29 + 7) ^ 8'(c << 3);
      msig[c] = 4'(c*5 + 3);
    end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < CH; c++) begin
      wr_en = 1; wr_ch = 5'(c); wr_data = mdat[c]; wr_sig = msig[c];
      @(negedge clk);
    end
    wr_en = 0;

    // R1: reset state
    setup(0, 0, 0, 0, 0, 0, 0);
    chk(ser_data === 0, "R1", "ser_data after reset", int'(ser_data), 0);
    chk(ser_sig === 0, "R1", "ser_sig after reset", int'(ser_sig), 0);
    chk(frame_err === 0, "R1", "frame_err after reset", int'(frame_err), 0);
    chk(irq === 0, "R1", "irq after reset", int'(irq), 0);

    // Single rate, same edges, no offset
    starts = '{1, 257};
    run(300, "R3/R6/R11 same edges");
    chk(frame_err === 0, "R8", "aligned pulses, flag", int'(frame_err), 0);

    // Single rate, pulse ahead, inverted, offsets
    setup(1, 0, 1, 0, 0, 3, 5);
    starts = '{1, 257};
    run(300, "R2/R3/R7 ahead inverted offset");
    chk(frame_err === 0, "R8", "aligned pulses, flag", int'(frame_err), 0);

    // Falling edges, wrap of the offset
    setup(1, 1, 0, 0, 0, 31, 7);
    starts = '{2, 258};
    run(300, "R3/R7 falling edges wrap");
    chk(frame_err === 0, "R8", "aligned pulses, flag", int'(frame_err), 0);

    // Double rate, first edge update, pulse held over both edges
    setup(0, 0, 0, 1, 0, 0, 0);
    starts = '{1, 513};
    run(560, "R4/R5 double first");
    chk(frame_err === 0, "R8", "double aligned, flag", int'(frame_err), 0);

    // Double rate, second edge update, pulse ahead, inverted, offset
    setup(0, 1, 1, 1, 1, 5, 2);
    starts = '{1, 513};
    run(560, "R4/R5/R7 double second");
    chk(frame_err === 0, "R8", "double aligned, flag", int'(frame_err), 0);

    // Misaligned pulse, interrupt, clear
    setup(1, 1, 0, 0, 0, 0, 0);
    cfg_irq_en = 1;
    starts = '{1, 257, 400};
    run(300, "R6 before misalign");
    chk(frame_err === 0, "R8", "flag before misaligned pulse", int'(frame_err), 0);
    run(150, "R8 realigned");
    chk(frame_err === 1, "R8", "flag after misaligned pulse", int'(frame_err), 1);
    chk(irq === 1, "R10", "irq enabled", int'(irq), 1);
    cfg_irq_en = 0;
    repeat (3) @(negedge clk);
    chk(irq === 0, "R10", "irq disabled", int'(irq), 0);
    chk(frame_err === 1, "R9", "flag sticky", int'(frame_err), 1);
    cfg_irq_en = 1;
    stat_clr = 1;
    @(negedge clk);
    stat_clr = 0;
    repeat (2) @(negedge clk);
    chk(frame_err === 0, "R9", "flag after clear", int'(frame_err), 0);
    chk(irq === 0, "R10", "irq after clear", int'(irq), 0);

    // Collision: clear held while a new misaligned pulse arrives
    rc0 = rise_cnt;
    stat_clr = 1;
    starts.push_back(500);
    run(150, "R8 realigned again");
    stat_clr = 0;
    chk(rise_cnt == rc0 + 1, "R9", "set wins over held clear, rises",
        rise_cnt - rc0, 1);
    chk(frame_err === 0, "R9", "flag after held clear", int'(frame_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule